// File: doc/BRIEF.md
# Two-Stage Serial Clock Rate Generator

This block turns the peripheral clock into the timing reference of a serial port. A 5-bit prescaler runs first. Its wrap drives a binary divider whose ratio is picked by a 3-bit code. The combined wrap is a single-cycle `half_tick` pulse. It fires once every N = P × D peripheral clocks, where P is the prescale value and D is the divider ratio. The serial clock level `sclk_level` toggles on every tick, so one serial bit period spans two ticks.

The frame engine controls the block with `gen_en` and a 16-bit configuration word. The prescale value minus one sits in bits 12:8. The divider code sits in bits 2:0. Codes 0 to 4 give D = 2, 4, 8, 16 and 32. Code 7 gives D = 1, but only when P is 1 or 2; with any larger P it is clamped to D = 2. Codes 5 and 6 act as D = 32. All other bits are ignored.

A two-state controller sequences the block:
- `GEN_IDLE` holds the counters at zero and copies the configuration every cycle.
- The transition *start* (enable sampled high) moves it to `GEN_RUN`.
- `GEN_RUN` counts, and loads a new configuration only at a tick.
- The transition *halt* (enable sampled low) returns it to `GEN_IDLE`.
- *hold* keeps either state.

Top module: `sbaud_gen`

## Requirements
- R1: While enabled, `half_tick` is high in the N-th cycle after the clock edge that first samples `gen_en` high, and again every N cycles after that, with N = P × D.
- R2: The prescale value P is cfg_word[12:8] + 1, covering 1 to 32.
- R3: Divider codes 0, 1, 2, 3, 4 in cfg_word[2:0] select D = 2, 4, 8, 16, 32.
- R4: Code 7 with P equal to 1 or 2 selects D = 1, so with P = 1 the tick is high in every cycle.
- R5: Code 7 with P greater than 2 is clamped to D = 2.
- R6: Codes 5 and 6 act as D = 32.
- R7: cfg_word bits 15:13 and 7:3 have no effect on the tick period.
- R8: `sclk_level` sits at the idle level (parameter, default 0) when the block is enabled. It inverts at the edge that ends each tick cycle and is otherwise stable while enabled.
- R9: In the cycle after `gen_en` is sampled low, `half_tick` is low and `sclk_level` is at the idle level. Counting restarts from zero on the next enable.
- R10: A configuration change while running takes effect only after the next tick. While disabled, the word present at the enabling edge is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Run enable from the frame engine |
| cfg_word | input | 16 | Prescaler and divider configuration |
| half_tick | output | 1 | One-cycle pulse every N clocks |
| sclk_level | output | 1 | Serial clock level, toggles per tick |

## Verification
The bench sweeps the divider codes against a spread of prescale values. It also sweeps every prescale value against the bypass code and the extreme codes. For each case it measures the first and second tick positions against the product computed in the bench.

The corner cases targeted are these:
- The bypass code on both sides of P = 2. A missing clamp would tick at half the expected period.
- The reserved codes. A decoder that wraps them would give ratios of 64 or 128, or ratios near 1.
- A configuration change in mid-period. A design that reloads at once would shorten the period in flight.
- Re-enabling after a single idle cycle. A counter that is not cleared would produce an early first tick.

Filler bits set around the fields show whether any of them leaks into the decode.

// File: rtl/sbaud_pkg.sv
package sbaud_pkg;
    localparam int CFG_W     = 16;
    localparam int PRE_W     = 5;
    localparam int PRE_LSB   = 8;
    localparam int SEL_W     = 3;
    localparam int SEL_LSB   = 0;
    localparam int DIV_CODES = 5;

    typedef enum logic [0:0] {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;
endpackage

// File: rtl/sbaud_decode.sv
module sbaud_decode #(
    parameter int CFG_W     = sbaud_pkg::CFG_W,
    parameter int PRE_W     = sbaud_pkg::PRE_W,
    parameter int PRE_LSB   = sbaud_pkg::PRE_LSB,
    parameter int SEL_W     = sbaud_pkg::SEL_W,
    parameter int SEL_LSB   = sbaud_pkg::SEL_LSB,
    parameter int DIV_CODES = sbaud_pkg::DIV_CODES
) (
    input  logic [CFG_W-1:0]     cfg_word,
    output logic [PRE_W-1:0]     pre_last,
    output logic [DIV_CODES-1:0] div_last
);
    localparam int LOG_W = $clog2(DIV_CODES + 1);
    localparam logic [SEL_W-1:0] SEL_BYPASS = '1;

    logic [SEL_W-1:0]     sel;
    logic [LOG_W-1:0]     dlog;
    logic [DIV_CODES:0]   ratio;

    assign sel      = cfg_word[SEL_LSB +: SEL_W];
    assign pre_last = cfg_word[PRE_LSB +: PRE_W];

    // exponent of the divider ratio; bypass is clamped when prescale exceeds 2
    always_comb begin
        if (sel == SEL_BYPASS) begin
            dlog = (pre_last <= PRE_W'(1)) ? LOG_W'(0) : LOG_W'(1);
        end else if (int'(sel) < DIV_CODES) begin
            dlog = LOG_W'(sel) + LOG_W'(1);
        end else begin
            dlog = LOG_W'(DIV_CODES);
        end
    end

    assign ratio    = (DIV_CODES+1)'(1) << dlog;
    assign div_last = DIV_CODES'(ratio - (DIV_CODES+1)'(1));
endmodule

// File: rtl/sbaud_count.sv
module sbaud_count #(
    parameter int PRE_W = sbaud_pkg::PRE_W,
    parameter int DIV_W = sbaud_pkg::DIV_CODES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_last,
    input  logic [DIV_W-1:0] div_last,
    output logic             wrap
);
    logic [PRE_W-1:0] pcnt;
    logic [DIV_W-1:0] dcnt;
    logic             pre_end;
    logic             div_end;

    assign pre_end = (pcnt == pre_last);
    assign div_end = (dcnt == div_last);
    assign wrap    = run && pre_end && div_end;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (pre_end) begin
            pcnt <= '0;
            dcnt <= div_end ? '0 : dcnt + DIV_W'(1);
        end else begin
            pcnt <= pcnt + PRE_W'(1);
        end
    end

    // prescale stage never passes its terminal count
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pcnt <= pre_last));

    // divider stage never passes its terminal count
    assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dcnt <= div_last));
endmodule

// File: rtl/sbaud_gen.sv
module sbaud_gen #(
    parameter int   CFG_W      = sbaud_pkg::CFG_W,
    parameter int   PRE_W      = sbaud_pkg::PRE_W,
    parameter int   PRE_LSB    = sbaud_pkg::PRE_LSB,
    parameter int   SEL_W      = sbaud_pkg::SEL_W,
    parameter int   SEL_LSB    = sbaud_pkg::SEL_LSB,
    parameter int   DIV_CODES  = sbaud_pkg::DIV_CODES,
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             half_tick,
    output logic             sclk_level
);
    import sbaud_pkg::*;

    gen_state_e state, state_nxt;

    logic [PRE_W-1:0]     dec_pre,  act_pre;
    logic [DIV_CODES-1:0] dec_div,  act_div;
    logic                 cnt_run;
    logic                 wrap;

    sbaud_decode #(
        .CFG_W(CFG_W), .PRE_W(PRE_W), .PRE_LSB(PRE_LSB),
        .SEL_W(SEL_W), .SEL_LSB(SEL_LSB), .DIV_CODES(DIV_CODES)
    ) u_decode (
        .cfg_word (cfg_word),
        .pre_last (dec_pre),
        .div_last (dec_div)
    );

    // next-state logic: start, halt, hold
    always_comb begin
        state_nxt = state;
        unique case (state)
            GEN_IDLE: if (gen_en)  state_nxt = GEN_RUN;
            GEN_RUN:  if (!gen_en) state_nxt = GEN_IDLE;
            default:  state_nxt = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GEN_IDLE;
        else        state <= state_nxt;
    end

    assign cnt_run = (state == GEN_RUN) && gen_en;

    sbaud_count #(.PRE_W(PRE_W), .DIV_W(DIV_CODES)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cnt_run),
        .pre_last (act_pre),
        .div_last (act_div),
        .wrap     (wrap)
    );

    assign half_tick = wrap;

    // active configuration: follows the input while idle, reloads only at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pre <= '0;
            act_div <= '0;
        end else if (state == GEN_IDLE || wrap) begin
            act_pre <= dec_pre;
            act_div <= dec_div;
        end
    end

    // output process: serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en) sclk_level <= IDLE_LEVEL;
        else if (wrap)         sclk_level <= ~sclk_level;
    end

    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (sclk_level == IDLE_LEVEL && !half_tick));

    assert_sclk_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && gen_en) |=> (sclk_level != $past(sclk_level)));

    assert_sclk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_tick && gen_en) |=> $stable(sclk_level));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_RUN && gen_en && !half_tick) |=> ($stable(act_pre) && $stable(act_div)));

    assert_bypass_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |-> (act_pre <= PRE_W'(1)));
endmodule

// File: tb/sbaud_gen_tb.sv
module sbaud_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        half_tick;
    logic        sclk_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    sbaud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .cfg_word(cfg_word),
        .half_tick(half_tick), .sclk_level(sclk_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int p, input int code);
        if (code <= 4) return 2 << code;
        if (code == 7) return (p <= 2) ? 1 : 2;
        return 32;
    endfunction

    function automatic string tag_of(input int p, input int code);
        if (code <= 4) return "R1 R2 R3";
        if (code == 7) return (p <= 2) ? "R1 R4" : "R1 R5";
        return "R1 R6";
    endfunction

    function automatic logic [15:0] mk_cfg(input int p, input int code);
        logic [4:0] pf;
        logic [2:0] cf;
        pf = 5'(p - 1);
        cf = 3'(code);
        return {3'b000, pf, 5'b00000, cf};
    endfunction

    // counts edges after enabling; returns positions of first two ticks
    task automatic measure(input int limit, output int t1, output int t2, output logic s2);
        int k = 0;
        t1 = 0; t2 = 0; s2 = 1'b0;
        while (t2 == 0 && k < limit) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (half_tick) begin
                if (t1 == 0) t1 = k;
                else begin t2 = k; s2 = sclk_level; end
            end
        end
    endtask

    task automatic run_case(input logic [15:0] c, input int n, input string tag);
        int t1, t2;
        logic s2;
        gen_en = 1'b0;
        cfg_word = c;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!half_tick && sclk_level == 1'b0, "R9 idle", int'(half_tick), 0);
        gen_en = 1'b1;
        measure(2 * n + 8, t1, t2, s2);
        check(t1 == n, tag, t1, n);
        check(t2 == 2 * n, tag, t2, 2 * n);
        check(s2 == 1'b1, "R8 sclk after first tick", int'(s2), 1);
        gen_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int plist[7] = '{1, 2, 3, 4, 7, 16, 32};
        int t1, t2, k;
        int ticks[3];
        int nt;
        logic s2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!half_tick && sclk_level == 1'b0, "R8 reset state", int'(sclk_level), 0);
        rst_n = 1'b1;

        // sweep A: every divider code over a spread of prescale values
        foreach (plist[i]) begin
            for (int code = 0; code < 8; code++) begin
                run_case(mk_cfg(plist[i], code), plist[i] * ratio_of(plist[i], code),
                         tag_of(plist[i], code));
            end
        end

        // sweep B: every prescale value with the bypass and extreme codes
        for (int p = 1; p <= 32; p++) begin
            run_case(mk_cfg(p, 7), p * ratio_of(p, 7), tag_of(p, 7));
            run_case(mk_cfg(p, 0), p * 2, "R1 R2 R3");
            run_case(mk_cfg(p, 4), p * 32, "R1 R2 R3");
        end

        // R7: filler bits around the fields: P=5, code 2 -> N=40
        run_case(16'hE4FA, 40, "R7 filler bits");

        // R9: disable mid-run, then re-enable after one idle cycle
        gen_en = 1'b0;
        cfg_word = mk_cfg(5, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        gen_en = 1'b1;
        repeat (14) @(posedge clk);
        @(negedge clk);
        gen_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!half_tick, "R9 tick low after disable", int'(half_tick), 0);
        check(sclk_level == 1'b0, "R9 sclk idle after disable", int'(sclk_level), 0);
        gen_en = 1'b1;
        measure(40, t1, t2, s2);
        check(t1 == 10, "R9 restart first tick", t1, 10);
        check(t2 == 20, "R9 restart second tick", t2, 20);
        gen_en = 1'b0;

        // R10: change mid-period from N=6 to N=4; ticks at 6, 12, 16
        cfg_word = mk_cfg(3, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        gen_en = 1'b1;
        k = 0; nt = 0;
        while (nt < 3 && k < 40) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (k == 8) cfg_word = mk_cfg(1, 1);
            if (half_tick) begin ticks[nt] = k; nt++; end
        end
        check(nt == 3 && ticks[0] == 6, "R10 first tick", ticks[0], 6);
        check(nt == 3 && ticks[1] == 12, "R10 old period kept", ticks[1], 12);
        check(nt == 3 && ticks[2] == 16, "R10 new period after tick", ticks[2], 16);
        gen_en = 1'b0;
        @(posedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule